// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Stretcher

This block guards a microcontroller core against runaway software. It sits idle after every reset and stays harmless until software writes a two-byte key, 0x1E followed directly by 0xE1, to its single write-only service register. From then on it counts machine-cycle ticks in a 14-bit counter. Software must repeat the same key before the counter runs out. Once armed, no write can stop it again; only a hardware reset or its own expiry does.

When the count expires, the block raises a one-clock internal reset request. Unless a configuration bit suppresses it, it also drives a reset-out line high for 98 oscillator clocks. Counting can be frozen while the core idles, under a configuration bit. It always stops in power-down. After a wake-up from power-down, counting stays held until the wake interrupt line (active low) has gone back high. The counter cannot be read or written except through the key.

Top module: `keyguard_wdt`

## Requirements
- R1: After hardware reset (rstN low) the watchdog is disarmed; wdtRst and rstOut are 0, and ticks alone never cause wdtRst.
- R2: A write of 0x1E to the service strobe, followed by a write of 0xE1 as the very next write, arms the watchdog with the counter at 0. Write cycles without tickEn do not count.
- R3: The key restarts if any write other than 0xE1 directly follows 0x1E, or if the first write is not 0x1E. The sequence 0x1E, 0x1E, 0xE1 therefore does not arm, while 0x5A, 0x1E, 0xE1 does.
- R4: While armed, the key sequence clears the counter, which then needs a full period again. If the key completes in the same cycle as expiry, the key wins.
- R5: A counted tick is a clock with tickEn high and no freeze. wdtRst pulses high for exactly one clock, in the clock after the 16383rd counted tick since arming or the last clear. After 16382 counted ticks it has not fired.
- R6: On expiry rstOut goes high in the same clock as wdtRst and stays high for exactly 98 clocks, unless cfgNoRstOut is 1, in which case rstOut stays 0.
- R7: Expiry disarms the watchdog and clears the counter and the key state, so further ticks cause no second wdtRst.
- R8: With cfgIdleHalt 0, ticks count while idleMode is 1. With cfgIdleHalt 1 they are ignored during idleMode, and counting resumes from the held value when idle ends.
- R9: Ticks are ignored while pdMode is 1. After pdMode falls, ticks stay ignored while extIntN is 0 and count again from the first clock extIntN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| wrEn | input | 1 | Write strobe for the service register (already address-decoded) |
| wrData | input | 8 | Write data for the service register |
| tickEn | input | 1 | Machine-cycle enable, one clock per machine cycle |
| idleMode | input | 1 | Core is in idle |
| pdMode | input | 1 | Core is in power-down |
| extIntN | input | 1 | Wake interrupt line, active low |
| cfgIdleHalt | input | 1 | 1 freezes counting during idle |
| cfgNoRstOut | input | 1 | 1 suppresses the reset-out pulse |
| wdtRst | output | 1 | One-clock internal reset request on expiry |
| rstOut | output | 1 | Stretched reset-out pulse, 98 clocks |

## Verification
A wrong key state or a wrong arm flag shows up only as a wdtRst that appears or fails to appear at the end of a full 16383-tick period. Each key pattern is therefore followed by that full run, with the fire cycle checked to the exact tick. A counter that drifts or freezes wrongly moves the fire point by at least one clock. This is caught by sampling just before and just at the expected tick. A wrong stretcher length is visible within about 100 clocks of expiry.

// File: rtl/keyguard_wdt_pkg.sv
package keyguard_wdt_pkg;

  typedef enum logic {
    KEY_WAIT_LO = 1'b0,
    KEY_WAIT_HI = 1'b1
  } keyState_e;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadPulse;
  } wdtStrobe_t;

endpackage

// File: rtl/keyguard_wdt_ctrl.sv
module keyguard_wdt_ctrl
  import keyguard_wdt_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       tickEn,
  input  logic       idleMode,
  input  logic       pdMode,
  input  logic       extIntN,
  input  logic       cfgIdleHalt,
  input  logic       cfgNoRstOut,
  input  logic       cntAtLimit,
  output wdtStrobe_t strb,
  output logic       wdtRst
);

  keyState_e keyState;
  logic      armed;
  logic      pdHold;
  logic      freeze;
  logic      countOk;
  logic      keyDone;
  logic      expire;

  // Counting is held in power-down and after it until the wake line is high.
  assign freeze  = pdMode || (pdHold && !extIntN) || (idleMode && cfgIdleHalt);
  assign countOk = armed && tickEn && !freeze;
  assign keyDone = wrEn && (keyState == KEY_WAIT_HI) && (wrData == KEY_SECOND);
  assign expire  = countOk && cntAtLimit && !keyDone;

  always_comb begin
    strb.clrCnt    = keyDone || expire;
    strb.incCnt    = countOk && !keyDone && !expire;
    strb.loadPulse = expire && !cfgNoRstOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KEY_WAIT_LO;
      armed    <= 1'b0;
      pdHold   <= 1'b0;
      wdtRst   <= 1'b0;
    end else begin
      wdtRst <= expire;
      if (pdMode)       pdHold <= 1'b1;
      else if (extIntN) pdHold <= 1'b0;
      if (expire) begin
        armed    <= 1'b0;
        keyState <= KEY_WAIT_LO;
      end else begin
        if (keyDone) armed <= 1'b1;
        if (wrEn) begin
          if (keyState == KEY_WAIT_LO && wrData == KEY_FIRST) keyState <= KEY_WAIT_HI;
          else                                                 keyState <= KEY_WAIT_LO;
        end
      end
    end
  end

  // R1 R7: a reset request can only come from an armed watchdog
  rst_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> $past(armed));

  // R7
  rst_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> !armed);

  // R5
  rst_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);

  // R9: no counting in power-down
  pd_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdMode |-> !strb.incCnt && !wdtRst);

endmodule

// File: rtl/keyguard_wdt_datapath.sv
module keyguard_wdt_datapath
  import keyguard_wdt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 98
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strb,
  output logic       cntAtLimit,
  output logic       rstOut
);

  localparam int                 PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0]   CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]   CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [PULSE_W-1:0] P_ONE = {{(PULSE_W-1){1'b0}}, 1'b1};
  localparam logic [PULSE_W-1:0] P_LOAD = PULSE_W'(PULSE_LEN);

  logic [CNT_W-1:0]   count;
  logic [PULSE_W-1:0] pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (strb.clrCnt) count <= '0;
    else if (strb.incCnt) count <= count + CNT_ONE;
  end

  // The tick that would make the count all ones is the expiring one.
  assign cntAtLimit = (count == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strb.loadPulse)  pulseCnt <= P_LOAD;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - P_ONE;
  end

  assign rstOut = (pulseCnt != '0);

  // R4 R5: the counter only steps up by one or returns to zero
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + CNT_ONE) || (count == '0));

  // R6: the stretcher starts only from a load request
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstOut) |-> $past(strb.loadPulse));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import keyguard_wdt_pkg::*;
#(
  parameter int         CNT_W      = 14,
  parameter int         PULSE_LEN  = 98,
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       tickEn,
  input  logic       idleMode,
  input  logic       pdMode,
  input  logic       extIntN,
  input  logic       cfgIdleHalt,
  input  logic       cfgNoRstOut,
  output logic       wdtRst,
  output logic       rstOut
);

  wdtStrobe_t strb;
  logic       cntAtLimit;

  keyguard_wdt_ctrl #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .tickEn     (tickEn),
    .idleMode   (idleMode),
    .pdMode     (pdMode),
    .extIntN    (extIntN),
    .cfgIdleHalt(cfgIdleHalt),
    .cfgNoRstOut(cfgNoRstOut),
    .cntAtLimit (cntAtLimit),
    .strb       (strb),
    .wdtRst     (wdtRst)
  );

  keyguard_wdt_datapath #(
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntAtLimit(cntAtLimit),
    .rstOut    (rstOut)
  );

  // R6: the stretched pulse never runs while reset-out is suppressed at expiry
  no_rstout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdtRst && $past(cfgNoRstOut)) |-> !rstOut);

endmodule

// File: tb/tb_keyguard_wdt.sv
module tb_keyguard_wdt;

  localparam int CLK_PERIOD = 10;
  localparam int FULL = 16383;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrData;
  logic       tickEn, idleMode, pdMode, extIntN, cfgIdleHalt, cfgNoRstOut;
  logic       wdtRst, rstOut;

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyguard_wdt dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tickEn(tickEn),
    .idleMode(idleMode), .pdMode(pdMode), .extIntN(extIntN),
    .cfgIdleHalt(cfgIdleHalt), .cfgNoRstOut(cfgNoRstOut),
    .wdtRst(wdtRst), .rstOut(rstOut)
  );

  // Key pattern table: bytes, count of bytes, whether it arms
  localparam int NV = 4;
  localparam logic [7:0] V_BYTES [NV][3] = '{
    '{8'h1E, 8'hE1, 8'h00},   // R2 plain key
    '{8'hE1, 8'h1E, 8'h00},   // R3 wrong order
    '{8'h1E, 8'h1E, 8'hE1},   // R3 repeated first byte
    '{8'h5A, 8'h1E, 8'hE1}    // R3 junk then good key
  };
  localparam int V_LEN [NV] = '{2, 2, 3, 3};
  localparam bit V_ARM [NV] = '{1'b1, 1'b0, 1'b0, 1'b1};

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic hwReset();
    rstN = 1'b0; wrEn = 1'b0; wrData = 8'h00; tickEn = 1'b0;
    idleMode = 1'b0; pdMode = 1'b0; extIntN = 1'b1;
    cfgIdleHalt = 1'b0; cfgNoRstOut = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n, output int saw);
    saw = 0;
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (wdtRst) saw++;
    end
    tickEn = 1'b0;
  endtask

  task automatic pulseLen(output int len);
    len = 0;
    while (rstOut && len < 200) begin
      len++;
      cyc();
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    int saw, len;
    hwReset();
    // R1 reset state
    check("R1 wdtRst after reset", int'(wdtRst), 0);
    check("R1 rstOut after reset", int'(rstOut), 0);

    // Table-driven key patterns, each followed by a full period
    for (int v = 0; v < NV; v++) begin
      hwReset();
      for (int b = 0; b < V_LEN[v]; b++) wr(V_BYTES[v][b]);
      runTicks(FULL - 1, saw);
      check("R5 no fire before last tick", saw, 0);
      runTicks(1, saw);
      check(V_ARM[v] ? "R2 key arms" : "R3 broken key stays disarmed", saw, int'(V_ARM[v]));
      if (V_ARM[v]) begin
        check("R6 rstOut with wdtRst", int'(rstOut), 1);
        cyc();
        check("R5 wdtRst one clock", int'(wdtRst), 0);
        pulseLen(len);
        check("R6 pulse length", len + 1, 98);
      end
    end

    // R4 service clears, with idle not halting (R8)
    hwReset();
    wr(8'h1E); wr(8'hE1);
    runTicks(10000, saw);
    check("R4 no fire mid period", saw, 0);
    wr(8'h1E); wr(8'hE1);
    idleMode = 1'b1;
    runTicks(FULL - 1, saw);
    check("R4 cleared counter no early fire", saw, 0);
    runTicks(1, saw);
    check("R8 counts in idle without halt", saw, 1);
    idleMode = 1'b0;

    // R8 idle halt freezes and resumes
    hwReset();
    wr(8'h1E); wr(8'hE1);
    runTicks(16000, saw);
    idleMode = 1'b1; cfgIdleHalt = 1'b1;
    runTicks(1000, saw);
    check("R8 frozen in idle", saw, 0);
    idleMode = 1'b0;
    runTicks(FULL - 16000 - 1, saw);
    check("R8 resumes held value", saw, 0);
    runTicks(1, saw);
    check("R8 fires after resume", saw, 1);

    // R9 power-down and wake hold
    hwReset();
    wr(8'h1E); wr(8'hE1);
    runTicks(16000, saw);
    pdMode = 1'b1; extIntN = 1'b0;
    runTicks(500, saw);
    check("R9 frozen in power-down", saw, 0);
    pdMode = 1'b0;
    runTicks(500, saw);
    check("R9 held while wake line low", saw, 0);
    extIntN = 1'b1;
    runTicks(FULL - 16000 - 1, saw);
    check("R9 resumes after wake line high", saw, 0);
    runTicks(1, saw);
    check("R9 fires after wake", saw, 1);

    // R6 suppressed reset-out, then R7 disarmed
    hwReset();
    cfgNoRstOut = 1'b1;
    wr(8'h1E); wr(8'hE1);
    runTicks(FULL, saw);
    check("R6 wdtRst with suppression", saw, 1);
    pulseLen(len);
    check("R6 rstOut suppressed", len, 0);
    runTicks(FULL + 10, saw);
    check("R7 disarmed after expiry", saw, 0);
    check("R7 rstOut quiet", int'(rstOut), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule